// File: doc/BRIEF.md
# Page-Mode DRAM Line Read Controller

This block fetches cache lines from an asynchronous page-mode DRAM that holds its output data (EDO behaviour). A bus master hands over a line address with a valid/ready handshake. The controller splits the address into a row part and a column part and drives both in turn on one shared set of address pins. It sequences the active-low row strobe, column strobe and write-enable, and returns the line as four 64-bit beats. Each beat comes with a one-cycle data-valid pulse, and the fourth beat is also tagged as last.

After a line is read, its row is left open. A request that lands in that row skips row activation and issues only column strobes, so its first beat arrives in the 3rd cycle instead of the 10th. Any other request first precharges, then opens the new row. A free-running timer asks for a refresh cycle in which the column strobe falls before the row strobe. The refresh is served only when no line read is in progress, and it closes the open row. Two counters record how many accepted requests hit the open page and how many missed it.

Top module: `dram_page_reader`

## Requirements
- R1: While reset is held, and in the first cycle after it, `req_ready` is 1, all three DRAM strobes are 1 (inactive), `rd_valid` is 0 and both counters are 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle up to, but not including, the cycle of the last beat.
- R3: A request whose row differs from the open row, or that arrives while no row is open, is a miss. RAS is high for the first three cycles after acceptance, with the row on the address pins in the third cycle. RAS falls in the fourth cycle. The first beat's `rd_valid` is high in the 10th cycle after the accepting edge.
- R4: A request to the open row is a hit. RAS stays low in every cycle of the access, and the first beat's `rd_valid` is high in the 3rd cycle after the accepting edge.
- R5: Beat k (k = 0..3) carries the word the DRAM drove while CAS was low at column address line_col*4 + k, where line_col is `req_addr[6:0]` and the row is `req_addr[16:7]`. `rd_last` is high only with the fourth beat.
- R6: `rd_valid` pulses last one cycle each and are never adjacent: beats are exactly 2 cycles apart.
- R7: `dram_we_n` stays 1 in every cycle.
- R8: Each accepted request adds exactly 1 to `hit_count` (hit) or to `miss_count` (miss).
- R9: Refresh is requested once every REFRESH_INTERVAL cycles. It starts only when no line read is in progress, ahead of any waiting request. In the refresh, CAS falls while RAS is high and RAS falls in the following cycle. The refresh closes the open row, so the next request is a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Line request valid |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_addr | input | 17 | Line address: row in [16:7], line column in [6:0] |
| dram_addr | output | 10 | Multiplexed row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe and output enable, active low |
| dram_we_n | output | 1 | Write enable, active low (reads only, held high) |
| dram_dq | input | 64 | DRAM data pins |
| rd_data | output | 64 | Returned beat |
| rd_valid | output | 1 | One-cycle pulse per returned beat |
| rd_last | output | 1 | Marks the fourth beat |
| hit_count | output | 16 | Requests that found their row open |
| miss_count | output | 16 | Requests that needed a row opening |

## Verification
If the open-row register or its open flag is wrong, the very next request shows the wrong first-beat latency: 3 cycles where 10 are due, or the reverse. In the same access, RAS either rises when it should stay low or stays low when it should rise, and the wrong counter moves. A beat counter that slips shows up within two cycles, as a wrong column word or as `rd_last` on the wrong beat. A stuck refresh timer shows at the pins as a gap between refresh cycles that is too long or too short.

// File: rtl/dpc_pkg.sv
// Package: shared types for the page-mode DRAM line reader.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package dpc_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_READ = 2'd1,
        SEQ_REFR = 2'd2
    } seq_state_t;
endpackage

// File: rtl/dpc_refresh_timer.sv
// Module: free-running refresh interval timer.
// Raises a pending flag every INTERVAL cycles. The flag stays up until the
// sequencer takes the refresh. Assumes INTERVAL >= 2.
module dpc_refresh_timer #(
    parameter int INTERVAL = 300,
    localparam int CW = $clog2(INTERVAL + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_take,
    output logic ref_pend
);
    logic [CW-1:0] tick;

    // Count cycles and set or clear the pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick     <= '0;
            ref_pend <= 1'b0;
        end else begin
            if (ref_take) ref_pend <= 1'b0;
            if (tick == CW'(INTERVAL - 1)) begin
                tick     <= '0;
                ref_pend <= 1'b1;
            end else begin
                tick <= tick + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dpc_page_tracker.sv
// Module: open-page tracker with hit and miss statistics.
// Remembers the row of the last accepted request and whether it is still
// open. Refresh closes it. Assumes accept and close are never both high.
module dpc_page_tracker #(
    parameter int ROW_W = 10,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [ROW_W-1:0] req_row,
    input  logic             close,
    output logic             page_hit,
    output logic             page_open,
    output logic [CNT_W-1:0] hit_cnt,
    output logic [CNT_W-1:0] miss_cnt
);
    logic [ROW_W-1:0] open_row;

    // Hit when a row is open and it matches the requested row.
    always_comb page_hit = page_open && (open_row == req_row);

    // Track the open row and count the hits and misses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_row  <= '0;
            page_open <= 1'b0;
            hit_cnt   <= '0;
            miss_cnt  <= '0;
        end else if (close) begin
            page_open <= 1'b0;
        end else if (accept) begin
            open_row  <= req_row;
            page_open <= 1'b1;
            if (page_hit) hit_cnt  <= hit_cnt + 1'b1;
            else          miss_cnt <= miss_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dpc_sequencer.sv
// Module: strobe and beat sequencer.
// A phase counter drives the RAS/CAS/address decode for line reads and for
// refresh cycles. Each beat is captured at the end of its CAS-low cycle. It
// relies on the DRAM holding its output data until the next CAS.
// Assumes MISS_LAT >= 8 and HIT_LAT >= 2.
module dpc_sequencer #(
    parameter int ROW_W    = 10,
    parameter int LCOL_W   = 7,
    parameter int BEATS    = 4,
    parameter int DATA_W   = 64,
    parameter int MISS_LAT = 10,
    parameter int HIT_LAT  = 3,
    parameter int PRE_CYC  = 2,
    parameter int REF_HOLD = 4,
    localparam int BEAT_W  = $clog2(BEATS),
    localparam int COL_W   = LCOL_W + BEAT_W,
    localparam int PIN_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              page_hit,
    input  logic              page_open,
    input  logic              ref_take,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [LCOL_W-1:0] req_lcol,
    input  logic [DATA_W-1:0] dram_dq,
    output logic              seq_idle,
    output logic [PIN_W-1:0]  dram_addr,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_last
);
    import dpc_pkg::*;

    localparam int MISS_CAS = MISS_LAT - 2;
    localparam int HIT_CAS  = HIT_LAT - 2;
    localparam int RAS_ON   = PRE_CYC + 1;
    localparam int REF_CAS  = PRE_CYC;
    localparam int REF_RAS  = PRE_CYC + 1;
    localparam int REF_END  = REF_RAS + REF_HOLD;
    localparam int PH_MAX   = MISS_CAS + 2 * BEATS + REF_END;
    localparam int PH_W     = $clog2(PH_MAX + 1);

    seq_state_t        state;
    logic [PH_W-1:0]   ph;
    logic              miss_r;
    logic [BEAT_W-1:0] beat;
    logic [ROW_W-1:0]  row_r;
    logic [LCOL_W-1:0] lcol_r;
    logic [PH_W-1:0]   first_cas;
    logic              cas_beat;
    logic              beat_end;

    // Phase of the first column strobe for this access.
    always_comb first_cas = miss_r ? PH_W'(MISS_CAS) : PH_W'(HIT_CAS);

    // A beat's CAS-low cycle: every other phase from the first CAS phase.
    always_comb begin
        cas_beat = (state == SEQ_READ) && (ph >= first_cas) && (ph[0] == first_cas[0]);
        beat_end = cas_beat && (beat == BEAT_W'(BEATS - 1));
    end

    always_comb seq_idle = (state == SEQ_IDLE);

    // Decode strobes and the address pins from the state and the phase.
    always_comb begin
        dram_ras_n = 1'b1;
        dram_cas_n = 1'b1;
        dram_addr  = '0;
        unique case (state)
            SEQ_IDLE: dram_ras_n = !page_open;
            SEQ_READ: begin
                dram_ras_n = miss_r && (ph < PH_W'(RAS_ON));
                dram_cas_n = !cas_beat;
                if (miss_r && (ph < PH_W'(MISS_CAS - 1)))
                    dram_addr = PIN_W'(row_r);
                else
                    dram_addr = PIN_W'({lcol_r, beat});
            end
            SEQ_REFR: begin
                dram_cas_n = !((ph >= PH_W'(REF_CAS)) && (ph < PH_W'(REF_END)));
                dram_ras_n = !((ph >= PH_W'(REF_RAS)) && (ph < PH_W'(REF_END)));
            end
            default: ;
        endcase
    end

    // Advance the state, the phase counter and the beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SEQ_IDLE;
            ph     <= '0;
            miss_r <= 1'b0;
            beat   <= '0;
            row_r  <= '0;
            lcol_r <= '0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    ph   <= '0;
                    beat <= '0;
                    if (ref_take) begin
                        state <= SEQ_REFR;
                    end else if (accept) begin
                        state  <= SEQ_READ;
                        miss_r <= !page_hit;
                        row_r  <= req_row;
                        lcol_r <= req_lcol;
                    end
                end
                SEQ_READ: begin
                    ph <= ph + 1'b1;
                    if (cas_beat) beat <= beat + 1'b1;
                    if (beat_end) state <= SEQ_IDLE;
                end
                SEQ_REFR: begin
                    ph <= ph + 1'b1;
                    if (ph == PH_W'(REF_END)) state <= SEQ_IDLE;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // Capture the held DRAM output as each CAS-low cycle closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_last  <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= cas_beat;
            rd_last  <= beat_end;
            if (cas_beat) rd_data <= dram_dq;
        end
    end
endmodule

// File: rtl/dram_page_reader.sv
// Module: top of the page-mode DRAM line reader.
// Ties the refresh timer, the page tracker and the sequencer together. A
// request is taken only when the sequencer is idle and no refresh is waiting.
// Assumes a read-only client: write-enable is held inactive.
module dram_page_reader #(
    parameter int ROW_W            = 10,
    parameter int LCOL_W           = 7,
    parameter int BEATS            = 4,
    parameter int DATA_W           = 64,
    parameter int CNT_W            = 16,
    parameter int MISS_LAT         = 10,
    parameter int HIT_LAT          = 3,
    parameter int REFRESH_INTERVAL = 300,
    localparam int BEAT_W = $clog2(BEATS),
    localparam int COL_W  = LCOL_W + BEAT_W,
    localparam int PIN_W  = (ROW_W > COL_W) ? ROW_W : COL_W,
    localparam int ADDR_W = ROW_W + LCOL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [PIN_W-1:0]  dram_addr,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    input  logic [DATA_W-1:0] dram_dq,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_last,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    logic              ref_pend;
    logic              ref_take;
    logic              seq_idle;
    logic              accept;
    logic              page_hit;
    logic              page_open;
    logic [ROW_W-1:0]  req_row;
    logic [LCOL_W-1:0] req_lcol;

    // Split the line address and form the handshake terms.
    always_comb begin
        req_row   = req_addr[ADDR_W-1 -: ROW_W];
        req_lcol  = req_addr[LCOL_W-1:0];
        req_ready = seq_idle && !ref_pend;
        accept    = req_valid && req_ready;
        ref_take  = seq_idle && ref_pend;
        dram_we_n = 1'b1;
    end

    dpc_refresh_timer #(.INTERVAL(REFRESH_INTERVAL)) refresh_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_take (ref_take),
        .ref_pend (ref_pend)
    );

    dpc_page_tracker #(.ROW_W(ROW_W), .CNT_W(CNT_W)) tracker_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_row   (req_row),
        .close     (ref_take),
        .page_hit  (page_hit),
        .page_open (page_open),
        .hit_cnt   (hit_count),
        .miss_cnt  (miss_count)
    );

    dpc_sequencer #(
        .ROW_W(ROW_W), .LCOL_W(LCOL_W), .BEATS(BEATS), .DATA_W(DATA_W),
        .MISS_LAT(MISS_LAT), .HIT_LAT(HIT_LAT)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .page_hit   (page_hit),
        .page_open  (page_open),
        .ref_take   (ref_take),
        .req_row    (req_row),
        .req_lcol   (req_lcol),
        .dram_dq    (dram_dq),
        .seq_idle   (seq_idle),
        .dram_addr  (dram_addr),
        .dram_ras_n (dram_ras_n),
        .dram_cas_n (dram_cas_n),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .rd_last    (rd_last)
    );
endmodule

// File: rtl/dram_page_reader_chk.sv
// Module: protocol checker for the page-mode DRAM line reader, bound to the top.
// Assumes the synchronous active-low reset of the design.
module dram_page_reader_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             dram_ras_n,
    input logic             dram_cas_n,
    input logic             rd_valid,
    input logic             rd_last,
    input logic [CNT_W-1:0] hit_count,
    input logic [CNT_W-1:0] miss_count
);
    logic [CNT_W:0] total;

    // Sum of both counters for the step check.
    always_comb total = {1'b0, hit_count} + {1'b0, miss_count};

    // R2: once a request is taken, the controller is busy in the next cycle.
    assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R3: a row opening is preceded by at least two precharge cycles.
    assert_precharge_before_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) && dram_cas_n) |-> $past(dram_ras_n, 2));

    // R5: a beat is reported only after a CAS-low cycle.
    assert_beat_after_cas_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!dram_cas_n));

    // R5: the last tag only rides on a valid beat.
    assert_last_with_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> rd_valid);

    // R6: valid pulses are never adjacent.
    assert_beat_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R8: each taken request moves the counters by exactly one.
    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (total == $past(total) + 1'b1));

    // R8: without a taken request the counters hold.
    assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> $stable(total));

    // R9: CAS low with RAS high is a refresh, so RAS falls next.
    assert_cas_before_ras_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_cas_n && dram_ras_n) |=> !dram_ras_n);
endmodule

bind dram_page_reader dram_page_reader_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .dram_ras_n (dram_ras_n),
    .dram_cas_n (dram_cas_n),
    .rd_valid   (rd_valid),
    .rd_last    (rd_last),
    .hit_count  (hit_count),
    .miss_count (miss_count)
);

// File: tb/dram_page_reader_tb_top.sv
// Bench: directed and seeded random line reads against an EDO DRAM model.
module dram_page_reader_tb_top;
    localparam int ROW_W   = 10;
    localparam int LCOL_W  = 7;
    localparam int PIN_W   = 10;
    localparam int ADDR_W  = 17;
    localparam int REF_INT = 300;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [PIN_W-1:0]  dram_addr;
    logic              dram_ras_n, dram_cas_n, dram_we_n;
    logic [63:0]       dram_dq;
    logic [63:0]       rd_data;
    logic              rd_valid, rd_last;
    logic [15:0]       hit_count, miss_count;

    int n_chk = 0;
    int n_err = 0;
    int exp_hits = 0;
    int exp_miss = 0;
    int n_ref = 0;
    int cyc = 0;
    int last_ref = -1;
    bit bench_open = 1'b0;
    logic [ROW_W-1:0] bench_row = '0;
    bit done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dram_page_reader dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_dq(dram_dq),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_last(rd_last),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    // DRAM content: a word computed from the row and the column.
    function automatic logic [63:0] word_at(input logic [PIN_W-1:0] r, input logic [PIN_W-1:0] c);
        return {16'hA5C3, 6'd0, r, 12'h3C9, c, r};
    endfunction

    // EDO DRAM model: latch the row when RAS falls, hold data after CAS rises.
    logic [PIN_W-1:0] row_lat = '0;
    logic             ras_prev = 1'b1;
    logic [63:0]      held = '0;
    always @(negedge clk) begin
        if (!dram_ras_n && ras_prev && dram_cas_n) row_lat <= dram_addr;
        ras_prev <= dram_ras_n;
        if (!dram_cas_n) held <= word_at(row_lat, dram_addr);
    end
    assign dram_dq = dram_cas_n ? held : word_at(row_lat, dram_addr);

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Refresh monitor: a CBR start closes the page; the gaps must match the interval.
    bit cbr_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !dram_cas_n && dram_ras_n && !cbr_prev) begin
            bench_open = 1'b0;
            n_ref++;
            if (last_ref >= 0)
                check((cyc - last_ref >= REF_INT - 24) && (cyc - last_ref <= REF_INT + 24),
                      "R9 refresh gap", 64'(cyc - last_ref), 64'(REF_INT));
            last_ref = cyc;
        end
        cbr_prev = rst_n && !dram_cas_n && dram_ras_n;
    end

    // One line read: wait for acceptance, then check every cycle of the access.
    task automatic do_req(input logic [ROW_W-1:0] row, input logic [LCOL_W-1:0] lcol);
        bit hit;
        int lat;
        int k;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = {row, lcol};
        while (!req_ready) @(negedge clk);
        hit = bench_open && (bench_row == row);
        bench_open = 1'b1;
        bench_row  = row;
        if (hit) exp_hits++; else exp_miss++;
        lat = hit ? 3 : 10;
        k = 0;
        for (int n = 1; n <= lat + 6; n++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (n < lat + 6) check(!req_ready, "R2 ready low during access", 64'(req_ready), 64'd0);
            check(dram_we_n, "R7 write enable high", 64'(dram_we_n), 64'd1);
            if (hit) check(!dram_ras_n, "R4 RAS held low on hit", 64'(dram_ras_n), 64'd0);
            else if (n <= 3) check(dram_ras_n, "R3 RAS high in precharge", 64'(dram_ras_n), 64'd1);
            else check(!dram_ras_n, "R3 RAS low after open", 64'(dram_ras_n), 64'd0);
            if (!hit && n == 3) check(dram_addr == PIN_W'(row), "R3 row on pins", 64'(dram_addr), 64'(row));
            if (n >= lat && ((n - lat) % 2 == 0)) begin
                check(rd_valid, hit ? "R4 beat timing" : "R3 beat timing", 64'(rd_valid), 64'd1);
                check(rd_data == word_at(PIN_W'(row), PIN_W'({lcol, 2'(k)})), "R5 beat data",
                      rd_data, word_at(PIN_W'(row), PIN_W'({lcol, 2'(k)})));
                check(rd_last == (k == 3), "R5 last tag", 64'(rd_last), 64'(k == 3));
                k++;
            end else begin
                check(!rd_valid, "R6 no beat here", 64'(rd_valid), 64'd0);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20241));
        repeat (3) @(negedge clk);
        check(req_ready && dram_ras_n && dram_cas_n && dram_we_n && !rd_valid,
              "R1 state in reset", {req_ready, dram_ras_n, dram_cas_n, dram_we_n, rd_valid}, 64'b11110);
        @(negedge clk) rst_n = 1'b1;
        check(req_ready && dram_ras_n && dram_cas_n && !rd_valid && hit_count == 0 && miss_count == 0,
              "R1 state after reset", {hit_count, miss_count, 4'(0)}, 64'd0);
        // Directed: first miss, hits in the same row, then stride across rows.
        do_req(10'd5, 7'd3);
        do_req(10'd5, 7'd9);
        do_req(10'd5, 7'd127);
        for (int r = 6; r < 10; r++) do_req(10'(r), 7'd3);
        do_req(10'd1023, 7'd0);
        do_req(10'd1023, 7'd64);
        // Random traffic over a few rows so hits and misses mix.
        for (int i = 0; i < 150; i++) begin
            int gap;
            gap = $urandom % 6;
            repeat (gap) @(negedge clk);
            do_req(10'($urandom % 3), 7'($urandom));
        end
        // Idle long enough for refresh; the next access must be a miss.
        repeat (REF_INT + 40) @(negedge clk);
        check(n_ref >= 2, "R9 refresh cycles seen", 64'(n_ref), 64'd2);
        check(!bench_open, "R9 page closed by refresh", 64'(bench_open), 64'd0);
        do_req(bench_row, 7'd5);
        repeat (2) @(negedge clk);
        check(hit_count == 16'(exp_hits), "R8 hit count", 64'(hit_count), 64'(exp_hits));
        check(miss_count == 16'(exp_miss), "R8 miss count", 64'(miss_count), 64'(exp_miss));
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end
endmodule